// File: doc/BRIEF.md
# Message Queue Manager

This block lets processors hand fixed-size messages to each other through hardware queues that are reached over a 32-bit register bus. Each queue has a window of sixteen word registers. A sender fills the lower fifteen registers of that window in any order and then writes the last one. That last write appends the whole message to the queue, and its data becomes the final word. A receiver can inspect the head message by reading the window. Reading the last register returns the final word and removes the message from the queue.

A separate status region gives one word per queue. That word holds the number of pending messages and a sticky flag that records a dropped commit. Each queue drives its own interrupt, which stays high while the queue holds at least one message.

Each queue's occupancy is tracked by a small state machine with three states:
- `Q_EMPTY` moves to `Q_PEND` on an accepted commit.
- `Q_PEND` moves to `Q_FULL` on a commit that fills the last slot.
- `Q_PEND` moves to `Q_EMPTY` on a pop of the only message.
- `Q_FULL` moves to `Q_PEND` on a pop.
- When DEPTH is 1, `Q_EMPTY` goes straight to `Q_FULL` on a commit, and `Q_FULL` goes straight back to `Q_EMPTY` on a pop.

All other combinations hold the current state.

Top module: `mq_manager`

## Requirements
- R1: For a data access, the queue index is taken from `bus_addr` starting at bit 7 and the register index from bits 6:2. Bits 16 and above select the sender/receiver window, and every window reaches the same queue. Registers 0–15 read as zero, and writes to them are ignored.
- R2: A full-word write to registers 16–30 stages that word. A full-word write to register 31 commits a message made of the fifteen staged words plus the write data as word 15. Staging is then cleared, so any word not written since the previous commit reads as zero.
- R3: Each queue returns messages in the order they were committed, and traffic on one queue never changes another queue.
- R4: A full-word read of registers 16–30 returns the matching word of the head message and does not change the queue. When the queue is empty these reads return zero.
- R5: A full-word read of register 31 returns word 15 of the head message and pops that message. On an empty queue it returns zero and the count stays the same.
- R6: A read with `bus_stat`=1 returns the status word for the queue in address bits 2 and up. The pending count is in bits 23:12, the overflow flag is in bit 0, and all other bits are zero. A full-word status write with bit 0 set clears that queue's overflow flag.
- R7: A commit to a queue that already holds DEPTH messages is dropped, the count stays at DEPTH, and the overflow flag is set.
- R8: `irq_o[q]` is high exactly while queue q holds one or more messages. It rises in the cycle after the commit and falls in the cycle after the last pop.
- R9: An access whose `bus_be` is not 4'hF changes nothing (no staging, commit, pop or flag clear) and reads as zero.
- R10: After reset every count, overflow flag, staged word and interrupt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_stat | input | 1 | 1 = status region, 0 = data windows |
| bus_addr | input | ADDR_W | Byte address within the selected region |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| irq_o | output | NUM_Q | Per-queue message-pending interrupt |

## Verification
The assertions assume at most one bus access per cycle. A commit and a pop therefore never reach the same queue in one cycle, and the count changes by at most one per clock. They also assume the queue index fields address only existing queues. The bench drives one access per clock through a single task, builds every address from queue numbers below NUM_Q, and applies partial byte enables only in the steps that test R9.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int MSG_WORDS = 16;
    localparam int WIDX_W    = 4;
    localparam int CNT_LSB   = 12;
    localparam int CNT_BITS  = 12;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PEND  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;

    function automatic logic is_word(input logic [3:0] be);
        return be == 4'hF;
    endfunction
endpackage

// File: rtl/mq_decode.sv
module mq_decode #(
    parameter int ADDR_W = 20,
    parameter int NUM_Q  = 4,
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_stat,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    output logic [QW-1:0]     q_idx,
    output logic [QW-1:0]     sq_idx,
    output logic [mq_pkg::WIDX_W-1:0] w_idx,
    output logic              stage_we,
    output logic              commit,
    output logic              pop,
    output logic              peek,
    output logic              stat_rd,
    output logic              stat_wr
);
    import mq_pkg::*;

    logic       legal;
    logic [4:0] reg_idx;
    logic       data_reg;
    logic       last_reg;
    logic       unused_bits;

    assign reg_idx     = bus_addr[6:2];
    assign data_reg    = reg_idx[4];
    assign last_reg    = reg_idx == 5'd31;
    assign q_idx       = bus_addr[7 +: QW];
    assign sq_idx      = bus_addr[2 +: QW];
    assign w_idx       = reg_idx[3:0];
    assign unused_bits = ^{bus_addr[1:0], bus_addr[ADDR_W-1:7+QW]};

    always_comb begin
        legal    = bus_req && is_word(bus_be);
        stage_we = legal && !bus_stat && bus_we && data_reg && !last_reg;
        commit   = legal && !bus_stat && bus_we && last_reg;
        pop      = legal && !bus_stat && !bus_we && last_reg;
        peek     = legal && !bus_stat && !bus_we && data_reg;
        stat_rd  = legal && bus_stat && !bus_we;
        stat_wr  = legal && bus_stat && bus_we;
    end
endmodule

// File: rtl/mq_queue.sv
module mq_queue #(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stage_we,
    input  logic [mq_pkg::WIDX_W-1:0] stage_sel,
    input  logic        commit,
    input  logic        pop,
    input  logic        ovf_clr,
    input  logic [31:0] wdata,
    input  logic [mq_pkg::WIDX_W-1:0] peek_sel,
    output logic [31:0] peek_word,
    output logic [CW-1:0] count,
    output logic        ovf,
    output logic        irq
);
    import mq_pkg::*;

    logic [31:0] stage [MSG_WORDS-1];
    logic [31:0] store [DEPTH][MSG_WORDS];
    logic [PW-1:0] wp, rp;
    qstate_e st, st_nx;
    logic accept, take;

    assign accept = commit && (st != Q_FULL);
    assign take   = pop && (st != Q_EMPTY);

    // staging words 0..14 (registers 16..30)
    always_ff @(posedge clk) begin
        for (int w = 0; w < MSG_WORDS - 1; w++) begin
            if (!rst_n || commit)
                stage[w] <= '0;
            else if (stage_we && stage_sel == w[WIDX_W-1:0])
                stage[w] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int w = 0; w < MSG_WORDS - 1; w++)
                store[wp][w] <= stage[w];
            store[wp][MSG_WORDS-1] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) begin
                wp    <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                count <= count + 1'b1;
            end
            if (take) begin
                rp    <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
                count <= count - 1'b1;
            end
            if (commit && st == Q_FULL)
                ovf <= 1'b1;
            else if (ovf_clr)
                ovf <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= Q_EMPTY;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            Q_EMPTY: if (accept) st_nx = (DEPTH == 1) ? Q_FULL : Q_PEND;
            Q_PEND: begin
                if (accept && count == CW'(DEPTH - 1)) st_nx = Q_FULL;
                else if (take && count == CW'(1))      st_nx = Q_EMPTY;
            end
            Q_FULL:  if (take) st_nx = (DEPTH == 1) ? Q_EMPTY : Q_PEND;
            default: st_nx = Q_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        irq       = (st != Q_EMPTY);
        peek_word = (st == Q_EMPTY) ? '0 : store[rp][peek_sel];
    end

    p_irq_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (count != '0));
    p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0) |=> count == $past(count) - 1'b1);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && ovf));
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/mq_manager.sv
module mq_manager #(
    parameter int ADDR_W = 20,
    parameter int NUM_Q  = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_stat,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_Q-1:0]  irq_o
);
    import mq_pkg::*;

    localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [QW-1:0]     q_idx, sq_idx;
    logic [WIDX_W-1:0] w_idx;
    logic stage_we, commit, pop, peek, stat_rd, stat_wr;
    logic [31:0]   word_a [NUM_Q];
    logic [CW-1:0] cnt_a  [NUM_Q];
    logic [NUM_Q-1:0] ovf_a;

    mq_decode #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q)) u_dec (
        .bus_req(bus_req), .bus_we(bus_we), .bus_stat(bus_stat),
        .bus_addr(bus_addr), .bus_be(bus_be),
        .q_idx(q_idx), .sq_idx(sq_idx), .w_idx(w_idx),
        .stage_we(stage_we), .commit(commit), .pop(pop), .peek(peek),
        .stat_rd(stat_rd), .stat_wr(stat_wr)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic sel, ssel;
        assign sel  = (q_idx == QW'(q));
        assign ssel = (sq_idx == QW'(q));
        mq_queue #(.DEPTH(DEPTH)) u_queue (
            .clk(clk), .rst_n(rst_n),
            .stage_we(stage_we && sel), .stage_sel(w_idx),
            .commit(commit && sel), .pop(pop && sel),
            .ovf_clr(stat_wr && ssel && bus_wdata[0]),
            .wdata(bus_wdata), .peek_sel(w_idx),
            .peek_word(word_a[q]), .count(cnt_a[q]),
            .ovf(ovf_a[q]), .irq(irq_o[q])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (stat_rd) begin
            bus_rdata[CNT_LSB +: CNT_BITS] = CNT_BITS'(cnt_a[sq_idx]);
            bus_rdata[0] = ovf_a[sq_idx];
        end else if (peek) begin
            bus_rdata = word_a[q_idx];
        end
    end

    p_partial_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_be != 4'hF) |=> $stable(irq_o));
    p_partial_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_be != 4'hF) |-> bus_rdata == '0);
endmodule

// File: tb/mq_manager_test.sv
`timescale 1ns/1ps
module mq_manager_test;
    localparam int NQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0, bus_stat = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NQ-1:0] irq_o;

    int tests = 0, fails = 0, seq = 0;
    bit done = 1'b0;
    logic [31:0] sb [NQ][$];

    always #10 clk = ~clk;

    mq_manager uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_stat(bus_stat), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [19:0] daddr(input int p, input int q, input int r);
        return 20'((p << 16) | (q << 7) | (r << 2));
    endfunction

    task automatic bus(input logic we, input logic st, input logic [19:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_stat = st;
        bus_addr = a; bus_be = be; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_req = 1'b0;
    endtask

    task automatic status(input int q, input logic [31:0] exp, input string rq);
        logic [31:0] rd;
        bus(1'b0, 1'b1, 20'(q * 4), 4'hF, '0, rd);
        check(rq, rd, exp);
    endtask

    // driver: writes a full message and pushes expected words
    task automatic send(input int q, input int p, input bit drop);
        logic [31:0] rd, w;
        seq++;
        for (int i = 0; i < 16; i++) begin
            w = {8'(q), 8'(seq), 8'(p), 8'(i)};
            bus(1'b1, 1'b0, daddr(p, q, 16 + i), 4'hF, w, rd);
            if (!drop) sb[q].push_back(w);
        end
    endtask

    // monitor: reads the head message and compares against the scoreboard
    task automatic recv(input int q, input int p, input string rq);
        logic [31:0] rd;
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, 1'b0, daddr(p, q, 16 + i), 4'hF, '0, rd);
            if (sb[q].size() == 0) check({rq, " underrun"}, rd, 32'h0);
            else check(rq, rd, sb[q].pop_front());
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        check("R10 irq", 32'(irq_o), 32'h0);
        for (int q = 0; q < NQ; q++) status(q, 32'h0, "R10 status");

        // R1/R3 three messages into q1 through different windows
        send(1, 0, 0); send(1, 2, 0); send(1, 5, 0);
        status(1, 32'h3000, "R6 count3");
        check("R8 irq q1 only", 32'(irq_o), 32'h2);
        // R4 peek of register 20 twice, queue unchanged
        bus(1'b0, 1'b0, daddr(0, 1, 20), 4'hF, '0, rd);
        check("R4 peek", rd, sb[1][4]);
        bus(1'b0, 1'b0, daddr(3, 1, 20), 4'hF, '0, rd);
        check("R4 peek again", rd, sb[1][4]);
        status(1, 32'h3000, "R4 count held");
        // R1 low registers
        bus(1'b1, 1'b0, daddr(0, 1, 5), 4'hF, 32'hDEAD_BEEF, rd);
        bus(1'b0, 1'b0, daddr(0, 1, 5), 4'hF, '0, rd);
        check("R1 low reg zero", rd, 32'h0);
        recv(1, 7, "R3 order");
        status(1, 32'h2000, "R5 pop dec");
        recv(1, 0, "R3 order");
        recv(1, 1, "R3 order");
        check("R8 irq fall", 32'(irq_o), 32'h0);
        status(1, 32'h0, "R5 drained");

        // R2 sparse message: only register 22 written, zero commit
        bus(1'b1, 1'b0, daddr(0, 0, 22), 4'hF, 32'h1234_5678, rd);
        bus(1'b1, 1'b0, daddr(0, 0, 31), 4'hF, 32'h0, rd);
        check("R8 irq rise", 32'(irq_o), 32'h1);
        for (int i = 0; i < 16; i++) sb[0].push_back(i == 6 ? 32'h1234_5678 : 32'h0);
        // R2 staging cleared: commit-only message is all zero
        bus(1'b1, 1'b0, daddr(0, 0, 31), 4'hF, 32'hAA, rd);
        for (int i = 0; i < 16; i++) sb[0].push_back(i == 15 ? 32'hAA : 32'h0);
        send(3, 1, 0);
        recv(0, 0, "R2 sparse");
        recv(0, 0, "R2 staging cleared");
        status(3, 32'h1000, "R3 isolation");
        recv(3, 0, "R3 q3");

        // R7 overflow on q2
        for (int k = 0; k < 4; k++) send(2, 0, 0);
        send(2, 0, 1);
        status(2, 32'h4001, "R7 full dropped");
        bus(1'b1, 1'b1, 20'(2 * 4), 4'hF, 32'h1, rd);
        status(2, 32'h4000, "R6 clear ovf");
        for (int k = 0; k < 4; k++) recv(2, 0, "R7 kept four");
        status(2, 32'h0, "R7 drained");

        // R5 pop of empty queue
        bus(1'b0, 1'b0, daddr(0, 3, 31), 4'hF, '0, rd);
        check("R5 empty pop", rd, 32'h0);
        status(3, 32'h0, "R5 empty count");

        // R9 partial accesses
        bus(1'b1, 1'b0, daddr(0, 3, 31), 4'h1, 32'h55, rd);
        status(3, 32'h0, "R9 byte commit");
        check("R9 irq", 32'(irq_o), 32'h0);
        send(3, 0, 0);
        bus(1'b0, 1'b0, daddr(0, 3, 31), 4'h3, '0, rd);
        check("R9 half read zero", rd, 32'h0);
        status(3, 32'h1000, "R9 no pop");
        recv(3, 0, "R9 data intact");
        check("R8 irq end", 32'(irq_o), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule